// File: doc/BRIEF.md
# Input Scan Sequencer with Channel Tags

This controller decides which analog input a converter looks at, and labels every result it passes on. In manual mode two address bits pick one channel, and the sequencer holds it. In scan mode the sequencer walks a fixed list of channels by itself. It moves to the next channel only after a settled result for the current one has been taken. A mode bit chooses between five single-ended inputs, each measured against a shared common input 6, and three fully differential pairs.

Whenever the selected channel changes, the block raises a one-cycle restart toward the decimation filter. It then throws away the words that the filter produces while it settles. The settled word goes out together with a 3-bit channel tag. The block also reports which of three correction register sets applies to the current channel, and which set the calibration inputs use. It produces only mux-select codes and does no analog switching.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is held, `outValid` is 0 and `filterSync` is 1.
- R2: Tags are as follows: 000–011 for inputs 1–4 against input 6; 100 for pair 1/2 and also for input 5 against 6; 101 for pair 3/4; 110 for pair 5/6; 111 for calibration.
- R3: `xfrSel` gives the correction register set. It is 1 for inputs 1 and 2 and for pair 1/2, 2 for inputs 3 and 4 and for pair 3/4, and 3 for input 5, for pair 5/6 and for calibration.
- R4: `calXfrSel` is 3 whenever `scanEn` is 1. Otherwise it equals `xfrSel`.
- R5: In manual single-ended mode, `addr` 0–3 selects inputs 1–4, and `muxSel` equals `addr`. In manual differential mode, `addr` 0–2 selects the pairs (`muxSel` 5–7) and `addr` 3 selects calibration (`muxSel` 8).
- R6: Scan in single-ended mode visits `muxSel` 0,1,2,3,4 and then wraps to 0.
- R7: Scan in differential mode visits `muxSel` 5,6,7 and then wraps to 5.
- R8: A channel change, including a scan step, raises `filterSync` for one cycle in the cycle after the change.
- R9: After a restart, the first SETTLE_WORDS-1 words are dropped and the next word is output. A word that arrives while `filterSync` is high is ignored.
- R10: In manual mode, once the channel has settled, every later word is output and no restart is issued.
- R11: Changing `scanEn` or `diffMode` during a scan restarts the sequence at its first channel.
- R12: `outValid` pulses one cycle after an accepted `wordValid`. `outData` holds that word and `outTag` holds the tag of the channel it was taken on.

Ports table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | 1 = automatic scan, 0 = manual |
| diffMode | input | 1 | 1 = differential pairs, 0 = single-ended against input 6 |
| addr | input | 2 | Manual channel address |
| wordValid | input | 1 | Filter word strobe |
| wordData | input | DATA_W | Filter word |
| filterSync | output | 1 | Filter restart pulse |
| muxSel | output | 4 | Mux code: 0–4 inputs 1–5, 5–7 pairs, 8 calibration |
| xfrSel | output | 2 | Correction register set of current channel |
| calXfrSel | output | 2 | Correction register set used by calibration inputs |
| outValid | output | 1 | Tagged result strobe |
| outData | output | DATA_W | Tagged result |
| outTag | output | 3 | Channel tag of result |

## Verification
The embedded properties check four things on every cycle:
- each result strobe follows a filter word, and the result carries that word;
- the scan position never leaves the list for the current mode;
- every scan step is followed by a restart pulse;
- the settle counter stays within its bound.

The order of channels, the tag and register values for each channel, how many words are dropped after a restart, and the restart of a scan when the mode changes partway through can only be shown by the bench's scenarios.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef logic [3:0] chanT;
  localparam chanT CH_CAL = 4'd8;
  localparam int NUM_SINGLE = 5;
  localparam int NUM_PAIR = 3;

  typedef struct packed {
    logic restart;
    logic advance;
    logic capture;
  } seqStrobeT;

  function automatic logic [2:0] tagOf(chanT c);
    logic [2:0] t;
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3: t = c[2:0];
      4'd4, 4'd5: t = 3'b100;
      4'd6: t = 3'b101;
      4'd7: t = 3'b110;
      default: t = 3'b111;
    endcase
    return t;
  endfunction

  function automatic logic [1:0] xfrOf(chanT c);
    logic [1:0] r;
    case (c)
      4'd0, 4'd1, 4'd5: r = 2'd1;
      4'd2, 4'd3, 4'd6: r = 2'd2;
      default: r = 2'd3;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int SETTLE_WORDS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic scanEn,
  input  logic diffMode,
  input  logic [1:0] addr,
  input  logic wordValid,
  output seqStrobeT strobes,
  output logic filterSync
);
  localparam int CNT_W = $clog2(SETTLE_WORDS + 1);
  localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(SETTLE_WORDS - 1);

  logic lastScan, lastDiff;
  logic [1:0] lastAddr;
  logic [CNT_W-1:0] skipCnt;
  logic cfgChange, atLast;

  always_comb begin
    cfgChange = (scanEn != lastScan) || (diffMode != lastDiff) ||
                (!scanEn && (addr != lastAddr));
    atLast = (skipCnt == SKIP_LAST);
    strobes.restart = cfgChange;
    strobes.capture = wordValid && atLast && !cfgChange && !filterSync;
    strobes.advance = strobes.capture && scanEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filterSync <= 1'b1;
      skipCnt <= '0;
      lastScan <= 1'b0;
      lastDiff <= 1'b0;
      lastAddr <= '0;
    end else begin
      lastScan <= scanEn;
      lastDiff <= diffMode;
      lastAddr <= addr;
      filterSync <= cfgChange || strobes.advance;
      if (cfgChange || strobes.advance)
        skipCnt <= '0;
      else if (wordValid && !filterSync && !atLast)
        skipCnt <= skipCnt + 1'b1;
    end
  end

  // R8: every scan step is followed by a filter restart
  p_step_resync_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> filterSync);

  // R9: settle counter stays within the discard window
  p_skip_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    skipCnt <= SKIP_LAST);
endmodule

// File: rtl/scan_seq_path.sv
module scan_seq_path
  import scan_seq_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic scanEn,
  input  logic diffMode,
  input  logic [1:0] addr,
  input  logic [DATA_W-1:0] wordData,
  input  seqStrobeT strobes,
  output logic [3:0] muxSel,
  output logic [1:0] xfrSel,
  output logic [1:0] calXfrSel,
  output logic outValid,
  output logic [DATA_W-1:0] outData,
  output logic [2:0] outTag
);
  localparam logic [2:0] LAST_SINGLE = 3'(NUM_SINGLE - 1);
  localparam logic [2:0] LAST_PAIR = 3'(NUM_PAIR - 1);

  logic [2:0] chPos;
  logic [2:0] lastPos;
  chanT chan;

  always_comb begin
    lastPos = diffMode ? LAST_PAIR : LAST_SINGLE;
    if (scanEn) begin
      if (diffMode)
        chan = (chPos > LAST_PAIR) ? chanT'(5) : chanT'(4'd5 + {1'b0, chPos});
      else
        chan = (chPos > LAST_SINGLE) ? chanT'(0) : chanT'({1'b0, chPos});
    end else begin
      if (diffMode)
        chan = (addr == 2'd3) ? CH_CAL : chanT'(4'd5 + {2'b00, addr});
      else
        chan = chanT'({2'b00, addr});
    end
    muxSel = chan;
    xfrSel = xfrOf(chan);
    calXfrSel = scanEn ? 2'd3 : xfrOf(chan);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chPos <= '0;
      outValid <= 1'b0;
      outData <= '0;
      outTag <= '0;
    end else begin
      if (strobes.restart)
        chPos <= '0;
      else if (strobes.advance)
        chPos <= (chPos >= lastPos) ? 3'd0 : chPos + 3'd1;
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outData <= wordData;
        outTag <= tagOf(chan);
      end
    end
  end

  // R12: a result only follows an accepted filter word
  p_out_from_word_r12: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobes.capture));

  // R12: the result carries the word that was presented
  p_data_latched_r12: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outData == $past(wordData));

  // R6 / R7: scan position stays inside the list of the current mode
  p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.restart |-> chPos <= lastPos);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SETTLE_WORDS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic scanEn,
  input  logic diffMode,
  input  logic [1:0] addr,
  input  logic wordValid,
  input  logic [DATA_W-1:0] wordData,
  output logic filterSync,
  output logic [3:0] muxSel,
  output logic [1:0] xfrSel,
  output logic [1:0] calXfrSel,
  output logic outValid,
  output logic [DATA_W-1:0] outData,
  output logic [2:0] outTag
);
  seqStrobeT strobes;

  scan_seq_ctrl #(.SETTLE_WORDS(SETTLE_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .diffMode(diffMode),
    .addr(addr), .wordValid(wordValid), .strobes(strobes),
    .filterSync(filterSync)
  );

  scan_seq_path #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .diffMode(diffMode),
    .addr(addr), .wordData(wordData), .strobes(strobes),
    .muxSel(muxSel), .xfrSel(xfrSel), .calXfrSel(calXfrSel),
    .outValid(outValid), .outData(outData), .outTag(outTag)
  );
endmodule

// File: tb/tb_scan_seq_top.sv
module tb_scan_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 24;
  localparam int SETTLE = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0, diffMode = 1'b0;
  logic [1:0] addr = '0;
  logic wordValid = 1'b0;
  logic [DATA_W-1:0] wordData = '0;
  logic filterSync, outValid;
  logic [3:0] muxSel;
  logic [1:0] xfrSel, calXfrSel;
  logic [DATA_W-1:0] outData;
  logic [2:0] outTag;

  int checks = 0, fails = 0;
  int wordSeq = 0;
  logic syncSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_seq_top #(.DATA_W(DATA_W), .SETTLE_WORDS(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .diffMode(diffMode),
    .addr(addr), .wordValid(wordValid), .wordData(wordData),
    .filterSync(filterSync), .muxSel(muxSel), .xfrSel(xfrSel),
    .calXfrSel(calXfrSel), .outValid(outValid), .outData(outData),
    .outTag(outTag)
  );

  typedef struct packed {
    logic diff;
    logic [1:0] a;
    logic [3:0] mux;
    logic [2:0] tag;
    logic [1:0] xfr;
  } vecT;

  localparam vecT MAN_VEC [8] = '{
    '{1'b0, 2'd0, 4'd0, 3'b000, 2'd1},
    '{1'b0, 2'd1, 4'd1, 3'b001, 2'd1},
    '{1'b0, 2'd2, 4'd2, 3'b010, 2'd2},
    '{1'b0, 2'd3, 4'd3, 3'b011, 2'd2},
    '{1'b1, 2'd0, 4'd5, 3'b100, 2'd1},
    '{1'b1, 2'd1, 4'd6, 3'b101, 2'd2},
    '{1'b1, 2'd2, 4'd7, 3'b110, 2'd3},
    '{1'b1, 2'd3, 4'd8, 3'b111, 2'd3}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one filter word; checks the result strobe, then leaves one idle cycle
  task automatic sendWord(input logic expValid, input int expTag, input string req);
    logic [DATA_W-1:0] d;
    @(negedge clk);
    wordSeq++;
    d = DATA_W'(24'h100000 + wordSeq);
    wordValid = 1'b1;
    wordData = d;
    @(negedge clk);
    wordValid = 1'b0;
    syncSeen = filterSync;
    chk(outValid == expValid, req, int'(outValid), int'(expValid));
    if (expValid) begin
      chk(outTag == 3'(expTag), req, int'(outTag), expTag);
      chk(outData == d, "R12 data", int'(outData), int'(d));
    end
    @(negedge clk);
  endtask

  task automatic setCfg(input logic s, input logic d, input logic [1:0] a);
    @(negedge clk);
    scanEn = s;
    diffMode = d;
    addr = a;
    @(negedge clk);
  endtask

  // settle one channel: SETTLE-1 dropped words, then one tagged result
  task automatic settleChannel(input int expTag, input string req);
    for (int w = 0; w < SETTLE - 1; w++) sendWord(1'b0, 0, "R9 discard");
    sendWord(1'b1, expTag, req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    chk(filterSync == 1'b1, "R1 filterSync", int'(filterSync), 1);
    rstN = 1'b1;

    // manual vector table: R2, R3, R4, R5, R8, R9, R10
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      scanEn = 1'b0;
      diffMode = MAN_VEC[i].diff;
      addr = MAN_VEC[i].a;
      @(negedge clk);
      if (i > 0) chk(filterSync == 1'b1, "R8 manual restart", int'(filterSync), 1);
      chk(muxSel == MAN_VEC[i].mux, "R5 muxSel", int'(muxSel), int'(MAN_VEC[i].mux));
      chk(xfrSel == MAN_VEC[i].xfr, "R3 xfrSel", int'(xfrSel), int'(MAN_VEC[i].xfr));
      chk(calXfrSel == MAN_VEC[i].xfr, "R4 manual cal", int'(calXfrSel), int'(MAN_VEC[i].xfr));
      @(negedge clk);
      settleChannel(int'(MAN_VEC[i].tag), "R2 tag");
      chk(syncSeen == 1'b0, "R10 no resync", int'(syncSeen), 0);
      sendWord(1'b1, int'(MAN_VEC[i].tag), "R10 continuous");
      chk(syncSeen == 1'b0, "R10 no resync", int'(syncSeen), 0);
    end

    // R6: single-ended scan, two laps
    setCfg(1'b1, 1'b0, 2'd0);
    @(negedge clk);
    for (int lap = 0; lap < 2; lap++)
      for (int k = 0; k < 5; k++) begin
        chk(muxSel == 4'(k), "R6 order", int'(muxSel), k);
        chk(xfrSel == 2'((k < 2) ? 1 : (k < 4) ? 2 : 3), "R3 scan xfr", int'(xfrSel),
            (k < 2) ? 1 : (k < 4) ? 2 : 3);
        chk(calXfrSel == 2'd3, "R4 scan cal", int'(calXfrSel), 3);
        settleChannel(k, "R6 tag");
        chk(syncSeen == 1'b1, "R8 scan restart", int'(syncSeen), 1);
      end

    // R7: differential scan, two laps
    setCfg(1'b1, 1'b1, 2'd0);
    @(negedge clk);
    for (int lap = 0; lap < 2; lap++)
      for (int k = 0; k < 3; k++) begin
        chk(muxSel == 4'(5 + k), "R7 order", int'(muxSel), 5 + k);
        chk(xfrSel == 2'(1 + k), "R3 pair xfr", int'(xfrSel), 1 + k);
        settleChannel(4 + k, "R7 tag");
        chk(syncSeen == 1'b1, "R8 scan restart", int'(syncSeen), 1);
      end

    // R11: mode change partway through a scan restarts at the first channel
    setCfg(1'b1, 1'b0, 2'd0);
    @(negedge clk);
    settleChannel(0, "R11 pre");
    settleChannel(1, "R11 pre");
    chk(muxSel == 4'd2, "R11 mid", int'(muxSel), 2);
    setCfg(1'b1, 1'b1, 2'd0);
    chk(muxSel == 4'd5, "R11 restart diff", int'(muxSel), 5);
    @(negedge clk);
    settleChannel(4, "R11 first tag");
    setCfg(1'b1, 1'b0, 2'd0);
    chk(muxSel == 4'd0, "R11 restart single", int'(muxSel), 0);

    // R9: word during the restart cycle is ignored, count starts after it
    @(negedge clk);
    scanEn = 1'b0;
    addr = 2'd2;
    wordValid = 1'b1;
    wordData = 24'hABCDEF;
    @(negedge clk);
    wordValid = 1'b0;
    chk(outValid == 1'b0, "R9 sync word", int'(outValid), 0);
    @(negedge clk);
    settleChannel(2, "R9 after sync");

    summary();
    $finish;
  end
endmodule